// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

A purely combinational 32-bit integer execution unit for a fixed-length RISC core. Each evaluation takes two source operands, a 5-bit shift amount and a 5-bit operation code. It returns one 32-bit result and a single overflow-trap flag. The unit covers several kinds of operation:

- add and subtract, each in a trapping signed form and a non-trapping unsigned form;
- the four bitwise logic operations;
- left, right, arithmetic-right and rotate-right shifts;
- signed and unsigned set-on-less-than;
- upper-half immediate placement;
- leading ones and leading zeros counts;
- byte swap within each halfword;
- byte sign extension.

The unit does not gate its own result. When a signed add or subtract overflows, the result port still shows the wrapped two's-complement value and the trap flag is raised. The surrounding pipeline uses the flag to cancel the register write and to enter its exception path.

Top module: `int_alu`

## Requirements
- R1: The operation code selects the result as follows: 0 add, 1 add-unsigned, 2 sub, 3 sub-unsigned, 4 and, 5 or, 6 xor, 7 nor, 8 shift-left, 9 shift-right, 10 arithmetic-shift-right, 11 rotate-right, 12 less-than signed, 13 less-than unsigned, 14 upper-immediate, 15 count leading ones, 16 count leading zeros, 17 halfword byte swap, 18 byte sign-extend. Add and sub (codes 0 to 3) return src_a + src_b or src_a - src_b modulo 2^32, and do so even when the trap is raised.
- R2: ovf_trap is 1 for code 0 or code 2 exactly when the signed two's-complement sum or difference does not fit in 32 bits.
- R3: ovf_trap is 0 for every code other than 0 and 2, including the unsigned add and subtract codes 1 and 3.
- R4: Codes 4 to 7 return the bitwise AND, OR, XOR and NOR of src_a and src_b.
- R5: Shift-left (8) and shift-right (9) move src_a by sh_amt positions and fill the vacated bits with zeros.
- R6: Arithmetic shift right (10) moves src_a right by sh_amt and copies src_a bit 31 into every vacated bit.
- R7: Rotate right (11) moves src_a right by sh_amt. The bits shifted out at the bottom re-enter at bit 31 downward.
- R8: For codes 8 to 11, an sh_amt of 0 returns src_a unchanged.
- R9: Code 12 returns 1 when src_a < src_b as signed numbers and 0 otherwise. Code 13 makes the same comparison as unsigned numbers. Bits 31:1 of the result are always zero.
- R10: Code 14 returns src_b[15:0] in bits 31:16 with bits 15:0 cleared. src_a has no effect.
- R11: Codes 15 and 16 return the number of consecutive ones (15) or zeros (16) in src_a, counting down from bit 31. An input made entirely of the matching bit returns 32.
- R12: Code 17 swaps the two bytes of each 16-bit halfword of src_a: bits 15:8 with 7:0, and bits 31:24 with 23:16.
- R13: Code 18 returns src_a[7:0] with bit 7 copied into bits 31:8.
- R14: Codes 19 to 31 are unused. They return a zero result with ovf_trap at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see R1) |
| src_a | input | 32 | First operand; the only operand of shifts, counts and byte operations |
| src_b | input | 32 | Second operand; its low 16 bits are the immediate for code 14 |
| sh_amt | input | 5 | Shift or rotate distance |
| res | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on add or sub |

## Verification
The hardest conditions to reach are the signed edges. One is a subtract or add whose operands have the sign pattern that can overflow but sit exactly on the limit. The other is a signed compare whose internal difference overflows, so the sign of the difference alone gives the wrong answer. Random operands rarely land there. The vector table therefore pins the extreme values 0x7FFFFFFF, 0x80000000, 0 and -1 against each other. A following random phase biases the top bits of the operands toward those patterns and checks every code against an independent model. That model detects overflow by widening to 64 bits, not by comparing sign bits.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLL   = 5'd8,
    OP_SRL   = 5'd9,
    OP_SRA   = 5'd10,
    OP_ROTR  = 5'd11,
    OP_SLT   = 5'd12,
    OP_SLTU  = 5'd13,
    OP_LUI   = 5'd14,
    OP_CLO   = 5'd15,
    OP_CLZ   = 5'd16,
    OP_WSBH  = 5'd17,
    OP_SEB   = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'd0,
    SK_RIGHT = 2'd1,
    SK_ARITH = 2'd2,
    SK_ROT   = 2'd3
  } shift_kind_e;

  // Signed overflow of a + b: the operands agree in sign and the sum does not.
  function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Signed overflow of a - b: the operands differ in sign and the result sign
  // does not follow the minuend.
  function automatic logic sub_ovf(input logic a_msb, input logic b_msb, input logic d_msb);
    return (a_msb != b_msb) && (d_msb != a_msb);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         ovf_add,
  output logic         ovf_sub,
  output logic         lt_signed,
  output logic         lt_unsigned
);

  logic [W:0] sum_wide;
  logic [W:0] diff_wide;

  // The subtract reuses an adder on the inverted subtrahend; its carry-out is
  // the "no borrow" indication for the unsigned compare.
  assign sum_wide  = {1'b0, opa} + {1'b0, opb};
  assign diff_wide = {1'b0, opa} + {1'b0, ~opb} + {{W{1'b0}}, 1'b1};

  assign sum  = sum_wide[W-1:0];
  assign diff = diff_wide[W-1:0];

  assign ovf_add = add_ovf(opa[W-1], opb[W-1], sum[W-1]);
  assign ovf_sub = sub_ovf(opa[W-1], opb[W-1], diff[W-1]);

  // Signed less-than corrects the difference sign by the overflow flag.
  assign lt_signed   = diff[W-1] ^ ovf_sub;
  assign lt_unsigned = ~diff_wide[W];

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  shift_kind_e    kind,
  output logic [W-1:0]   dout
);

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic         is_left;
  logic         is_rot;
  logic         fill_bit;
  logic [W-1:0] stg [0:SHW];

  assign is_left  = (kind == SK_LEFT);
  assign is_rot   = (kind == SK_ROT);
  assign fill_bit = (kind == SK_ARITH) ? din[W-1] : 1'b0;

  // Left shifts run through the right-shift network on a mirrored word.
  assign stg[0] = is_left ? bit_rev(din) : din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] upper;
    assign upper      = is_rot ? stg[k][S-1:0] : {S{fill_bit}};
    assign stg[k+1]   = amt[k] ? {upper, stg[k][W-1:S]} : stg[k];
  end

  assign dout = is_left ? bit_rev(stg[SHW]) : stg[SHW];

endmodule

// File: rtl/alu_lead_cnt.sv
module alu_lead_cnt #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  logic          count_ones,
  output logic [CW-1:0] cnt
);

  function automatic logic [CW-1:0] lead_zeros(input logic [W-1:0] v);
    logic [CW-1:0] n;
    logic          hit;
    n   = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n   = n + CW'(1);
      end
    end
    return n;
  endfunction

  logic [W-1:0] scan;

  // Leading ones are leading zeros of the complement.
  assign scan = count_ones ? ~din : din;
  assign cnt  = lead_zeros(scan);

endmodule

// File: rtl/alu_bytes.sv
module alu_bytes #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] swapped,
  output logic [W-1:0] sext
);

  localparam int NH = W / 16;

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign swapped[h*16     +: 8] = din[h*16 + 8 +: 8];
    assign swapped[h*16 + 8 +: 8] = din[h*16     +: 8];
  end

  assign sext = {{(W-8){din[7]}}, din[7:0]};

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [4:0]     op_sel,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  input  logic [SHW-1:0] sh_amt,
  output logic [W-1:0]   res,
  output logic           ovf_trap
);

  localparam int CW   = SHW + 1;
  localparam int HALF = W / 2;

  alu_op_e      op_e;
  shift_kind_e  sh_kind;

  logic [W-1:0] sum_w;
  logic [W-1:0] diff_w;
  logic         ovf_add_w;
  logic         ovf_sub_w;
  logic         lt_s_w;
  logic         lt_u_w;
  logic [W-1:0] shift_w;
  logic [CW-1:0] lead_w;
  logic [W-1:0] swap_w;
  logic [W-1:0] sext_w;
  logic [W-1:0] upper_imm_w;

  assign op_e = alu_op_e'(op_sel);

  alu_addsub #(.W(W)) u_addsub (
    .opa         (src_a),
    .opb         (src_b),
    .sum         (sum_w),
    .diff        (diff_w),
    .ovf_add     (ovf_add_w),
    .ovf_sub     (ovf_sub_w),
    .lt_signed   (lt_s_w),
    .lt_unsigned (lt_u_w)
  );

  always_comb begin
    case (op_e)
      OP_SLL:  sh_kind = SK_LEFT;
      OP_SRA:  sh_kind = SK_ARITH;
      OP_ROTR: sh_kind = SK_ROT;
      default: sh_kind = SK_RIGHT;
    endcase
  end

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .din  (src_a),
    .amt  (sh_amt),
    .kind (sh_kind),
    .dout (shift_w)
  );

  alu_lead_cnt #(.W(W), .CW(CW)) u_lead (
    .din        (src_a),
    .count_ones (op_e == OP_CLO),
    .cnt        (lead_w)
  );

  alu_bytes #(.W(W)) u_bytes (
    .din     (src_a),
    .swapped (swap_w),
    .sext    (sext_w)
  );

  assign upper_imm_w = {src_b[HALF-1:0], {HALF{1'b0}}};

  always_comb begin
    case (op_e)
      OP_ADD, OP_ADDU: res = sum_w;
      OP_SUB, OP_SUBU: res = diff_w;
      OP_AND:          res = src_a & src_b;
      OP_OR:           res = src_a | src_b;
      OP_XOR:          res = src_a ^ src_b;
      OP_NOR:          res = ~(src_a | src_b);
      OP_SLL, OP_SRL,
      OP_SRA, OP_ROTR: res = shift_w;
      OP_SLT:          res = {{(W-1){1'b0}}, lt_s_w};
      OP_SLTU:         res = {{(W-1){1'b0}}, lt_u_w};
      OP_LUI:          res = upper_imm_w;
      OP_CLO, OP_CLZ:  res = {{(W-CW){1'b0}}, lead_w};
      OP_WSBH:         res = swap_w;
      OP_SEB:          res = sext_w;
      default:         res = '0;
    endcase
  end

  // Only the signed forms trap; the wrapped value stays on res.
  assign ovf_trap = ((op_e == OP_ADD) & ovf_add_w) | ((op_e == OP_SUB) & ovf_sub_w);

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input logic [4:0]     op_sel,
  input logic [W-1:0]   src_a,
  input logic [W-1:0]   src_b,
  input logic [SHW-1:0] sh_amt,
  input logic [W-1:0]   res,
  input logic           ovf_trap
);

  logic is_shift;
  assign is_shift = (op_sel >= OP_SLL) && (op_sel <= OP_ROTR);

  always_comb begin
    if (!$isunknown({op_sel, src_a, src_b, sh_amt, res, ovf_trap})) begin
      // R2: a trapping add needs equal operand signs and a flipped result sign
      a_r2_add_trap_cause: assert (!(ovf_trap && op_sel == OP_ADD) ||
                                   (src_a[W-1] == src_b[W-1] && res[W-1] != src_a[W-1]))
        else $error("a_r2_add_trap_cause");
      // R2: a trapping sub needs differing operand signs and a result sign unlike src_a
      a_r2_sub_trap_cause: assert (!(ovf_trap && op_sel == OP_SUB) ||
                                   (src_a[W-1] != src_b[W-1] && res[W-1] != src_a[W-1]))
        else $error("a_r2_sub_trap_cause");
      // R3: no other code may trap
      a_r3_no_overflow: assert (!ovf_trap || op_sel == OP_ADD || op_sel == OP_SUB)
        else $error("a_r3_no_overflow");
      // R8: a zero distance passes src_a through
      a_r8_zero_amount: assert (!(is_shift && sh_amt == '0) || res == src_a)
        else $error("a_r8_zero_amount");
      // R9: compare results are 0 or 1
      a_r9_flag_width: assert (!(op_sel == OP_SLT || op_sel == OP_SLTU) || res[W-1:1] == '0)
        else $error("a_r9_flag_width");
      // R10: lower half cleared
      a_r10_low_clear: assert (op_sel != OP_LUI || res[W/2-1:0] == '0)
        else $error("a_r10_low_clear");
      // R11: a count never exceeds the width
      a_r11_count_range: assert (!(op_sel == OP_CLO || op_sel == OP_CLZ) || res <= W)
        else $error("a_r11_count_range");
      // R13: every upper bit equals bit 7
      a_r13_sign_fill: assert (op_sel != OP_SEB || res[W-1:8] == {(W-8){res[7]}})
        else $error("a_r13_sign_fill");
      // R14: unused codes are silent
      a_r14_unused_zero: assert (op_sel <= OP_SEB || (res == '0 && !ovf_trap))
        else $error("a_r14_unused_zero");
    end
  end

endmodule

bind int_alu int_alu_chk #(.W(W), .SHW(SHW)) u_int_alu_chk (
  .op_sel   (op_sel),
  .src_a    (src_a),
  .src_b    (src_b),
  .sh_amt   (sh_amt),
  .res      (res),
  .ovf_trap (ovf_trap)
);

// File: tb/test_int_alu.sv
`timescale 1ns/1ps
module test_int_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [4:0]  sh_amt = '0;
  logic [31:0] res;
  logic        ovf_trap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_alu i_int_alu (
    .op_sel   (op_sel),
    .src_a    (src_a),
    .src_b    (src_b),
    .sh_amt   (sh_amt),
    .res      (res),
    .ovf_trap (ovf_trap)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [31:0] exp;
    logic        trap;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  32'h00000005, 32'h00000007, 5'd0,  32'h0000000C, 1'b0, 4'd1},  // R1
    '{5'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1, 4'd2},  // R2
    '{5'd0,  32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1, 4'd2},  // R2
    '{5'd1,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0, 4'd3},  // R3
    '{5'd2,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1, 4'd2},  // R2
    '{5'd2,  32'h00000003, 32'h00000005, 5'd0,  32'hFFFFFFFE, 1'b0, 4'd1},  // R1
    '{5'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0, 4'd3},  // R3
    '{5'd2,  32'h00000000, 32'h80000000, 5'd0,  32'h80000000, 1'b1, 4'd2},  // R2
    '{5'd4,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hF000F000, 1'b0, 4'd4},  // R4
    '{5'd5,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hFFF0FFF0, 1'b0, 4'd4},  // R4
    '{5'd6,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h0FF00FF0, 1'b0, 4'd4},  // R4
    '{5'd7,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'h000F000F, 1'b0, 4'd4},  // R4
    '{5'd8,  32'h80000001, 32'h00000000, 5'd4,  32'h00000010, 1'b0, 4'd5},  // R5
    '{5'd9,  32'h80000001, 32'h00000000, 5'd4,  32'h08000000, 1'b0, 4'd5},  // R5
    '{5'd10, 32'h80000001, 32'h00000000, 5'd4,  32'hF8000000, 1'b0, 4'd6},  // R6
    '{5'd10, 32'h7FFFFFFF, 32'h00000000, 5'd31, 32'h00000000, 1'b0, 4'd6},  // R6
    '{5'd10, 32'h80000000, 32'h00000000, 5'd31, 32'hFFFFFFFF, 1'b0, 4'd6},  // R6
    '{5'd11, 32'h80000001, 32'h00000000, 5'd4,  32'h18000000, 1'b0, 4'd7},  // R7
    '{5'd11, 32'h12345678, 32'h00000000, 5'd8,  32'h78123456, 1'b0, 4'd7},  // R7
    '{5'd8,  32'h12345678, 32'h00000000, 5'd0,  32'h12345678, 1'b0, 4'd8},  // R8
    '{5'd11, 32'h12345678, 32'h00000000, 5'd0,  32'h12345678, 1'b0, 4'd8},  // R8
    '{5'd10, 32'h87654321, 32'h00000000, 5'd0,  32'h87654321, 1'b0, 4'd8},  // R8
    '{5'd12, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 1'b0, 4'd9},  // R9
    '{5'd13, 32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0, 4'd9},  // R9
    '{5'd12, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001, 1'b0, 4'd9},  // R9
    '{5'd13, 32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000000, 1'b0, 4'd9},  // R9
    '{5'd12, 32'h00000005, 32'h00000005, 5'd0,  32'h00000000, 1'b0, 4'd9},  // R9
    '{5'd14, 32'hFFFFFFFF, 32'hDEADBEEF, 5'd0,  32'hBEEF0000, 1'b0, 4'd10}, // R10
    '{5'd16, 32'h00000000, 32'h00000000, 5'd0,  32'd32,       1'b0, 4'd11}, // R11
    '{5'd16, 32'h00010000, 32'h00000000, 5'd0,  32'd15,       1'b0, 4'd11}, // R11
    '{5'd16, 32'h80000000, 32'h00000000, 5'd0,  32'd0,        1'b0, 4'd11}, // R11
    '{5'd15, 32'hFFFFFFFF, 32'h00000000, 5'd0,  32'd32,       1'b0, 4'd11}, // R11
    '{5'd15, 32'hFF00FFFF, 32'h00000000, 5'd0,  32'd8,        1'b0, 4'd11}, // R11
    '{5'd15, 32'h7FFFFFFF, 32'h00000000, 5'd0,  32'd0,        1'b0, 4'd11}, // R11
    '{5'd17, 32'h11223344, 32'h00000000, 5'd0,  32'h22114433, 1'b0, 4'd12}, // R12
    '{5'd18, 32'h12345680, 32'h00000000, 5'd0,  32'hFFFFFF80, 1'b0, 4'd13}, // R13
    '{5'd18, 32'hABCDEF7F, 32'h00000000, 5'd0,  32'h0000007F, 1'b0, 4'd13}, // R13
    '{5'd19, 32'h12345678, 32'h87654321, 5'd3,  32'h00000000, 1'b0, 4'd14}, // R14
    '{5'd31, 32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0, 4'd14}, // R14
    '{5'd4,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 1'b0, 4'd3},  // R3
    '{5'd9,  32'h12345678, 32'h00000000, 5'd0,  32'h12345678, 1'b0, 4'd8}   // R8
  };

  function automatic string req_of(input int op);
    case (op)
      0, 2:           return "R1/R2";
      1, 3:           return "R1/R3";
      4, 5, 6, 7:     return "R4";
      8, 9:           return "R5";
      10:             return "R6";
      11:             return "R7";
      12, 13:         return "R9";
      14:             return "R10";
      15, 16:         return "R11";
      17:             return "R12";
      18:             return "R13";
      default:        return "R14";
    endcase
  endfunction

  // Independent model: overflow by 64-bit widening, shifts by language operators.
  function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                input int sh, output logic [31:0] r, output logic t);
    longint wide;
    logic [63:0] dbl;
    int n;
    r = '0;
    t = 1'b0;
    case (op)
      0, 1: begin
        wide = longint'($signed(a)) + longint'($signed(b));
        r = wide[31:0];
        t = (op == 0) && (wide != longint'($signed(r)));
      end
      2, 3: begin
        wide = longint'($signed(a)) - longint'($signed(b));
        r = wide[31:0];
        t = (op == 2) && (wide != longint'($signed(r)));
      end
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  r = ~(a | b);
      8:  r = a << sh;
      9:  r = a >> sh;
      10: r = $signed(a) >>> sh;
      11: begin dbl = {a, a} >> sh; r = dbl[31:0]; end
      12: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      13: r = (a < b) ? 32'd1 : 32'd0;
      14: r = {b[15:0], 16'h0000};
      15, 16: begin
        n = 0;
        while (n < 32 && a[31-n] == (op == 15)) n++;
        r = n;
      end
      17: r = {a[23:16], a[31:24], a[7:0], a[15:8]};
      18: r = {{24{a[7]}}, a[7:0]};
      default: r = '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input logic got_t, input logic exp_t);
    checks++;
    if (got !== exp || got_t !== exp_t) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: res=%h trap=%b expected res=%h trap=%b",
               tag, op_sel, src_a, src_b, sh_amt, got, got_t, exp, exp_t);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh);
    @(posedge clk);
    op_sel = op;
    src_a  = a;
    src_b  = b;
    sh_amt = sh;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [31:0] mr;
    logic        mt;

    // R1: quiet inputs during reset give a zero sum without trap
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", res, 32'h0, ovf_trap, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), res, VECS[i].exp, ovf_trap, VECS[i].trap);
    end

    // R10: changing src_a leaves the upper-immediate result alone
    apply(5'd14, 32'h00000000, 32'h00001234, 5'd17);
    check("R10 a-ignored", res, 32'h12340000, ovf_trap, 1'b0);

    // Random phase, operand tops biased toward the signed limits
    lfsr = 32'h1ACE5EED;
    for (int i = 0; i < 1200; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      ra = lfsr;
      rb = {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A5A5A;
      case (i % 4)
        0: begin ra[31:30] = 2'b01; rb[31:30] = 2'b01; end
        1: begin ra[31:30] = 2'b10; rb[31:30] = 2'b01; end
        2: begin ra[31:28] = 4'hF; ra[27:0] = ra[27:0] >> lfsr[4:0]; end
        default: ;
      endcase
      apply(5'(i % 22), ra, rb, lfsr[9:5]);
      model(i % 22, ra, rb, int'(lfsr[9:5]), mr, mt);
      check(req_of(i % 22), res, mr, ovf_trap, mt);
    end

    finish_run();
  end

endmodule